// File: doc/BRIEF.md
# Chained Debug Trigger Resolver

This block decides which hardware debug triggers actually fire. Raw match results from address and data comparators arrive as one bit per trigger; the block combines them with per-trigger configuration (enable, timing) and a per-pair chain setting, all held in a small register file. Configuration is loaded one entry per cycle through a valid/index/data write port.

Triggers are organised in fixed pairs, trigger 2i with trigger 2i+1. Each trigger has a fixed role. In pair order, the roles are: fetch+fetch, store+store, load+load, fetch+store, fetch+load. When the pair count exceeds five, the pattern repeats. A chained pair fires only as a unit. A pair made of two store triggers can never be chained.

The outputs are all combinational from the hit inputs and the registered configuration. They are:
- a fire vector;
- a trap-on-this-instruction flag and a trap-on-next-instruction flag;
- fetch-side, memory-side and overall hit summaries.

Top module: `trig_resolver`

## Requirements
- R1: After reset every trigger is disabled, every chain setting is off and every timing bit is 0, so no output is asserted whatever the hit inputs are.
- R2: A write with `cfgWrValid` high and `cfgWrIdx` below the trigger count loads that trigger's enable (data bit 0) and timing (data bit 1). The new values act from the next clock edge. A write whose index is at or above the trigger count changes nothing.
- R3: A trigger whose pair is not chained fires exactly when it is enabled and its hit input is high, independent of its partner.
- R4: In a chained pair, both triggers fire when both are enabled and both hit, and neither fires otherwise. This includes the case where one member is disabled.
- R5: In a chained pair whose two timing bits differ, neither trigger fires, even when both are enabled and hit.
- R6: The chain setting of pair i is loaded from data bit 2 of a write to the even index 2i. A write to an odd index leaves every chain setting unchanged.
- R7: A pair whose two triggers both have the store role is never chained, whatever value is written to its chain bit.
- R8: `fireNow` is the OR of fired triggers with timing 0. `fireNext` is the OR of fired triggers with timing 1.
- R9: Among fired triggers, `fetchHit` is the OR of those with the fetch role and `memHit` is the OR of those with the store or load role. `anyHit` is `fetchHit | memHit`. In the default bank the fetch-role triggers are indices 0, 1, 6 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrValid | input | 1 | Configuration write strobe |
| cfgWrIdx | input | 4 | Trigger index to write |
| cfgWrData | input | 3 | bit0 enable, bit1 timing, bit2 chain (taken at even indices) |
| hitVec | input | 10 | Raw comparator match per trigger |
| fireVec | output | 10 | Triggers that fire |
| fireNow | output | 1 | Trap on the current instruction |
| fireNext | output | 1 | Trap on the next instruction |
| fetchHit | output | 1 | Some fetch-role trigger fired |
| memHit | output | 1 | Some store- or load-role trigger fired |
| anyHit | output | 1 | Some trigger fired |

## Verification
Hit inputs reach every output in the same cycle, with no register on the way. A configuration write takes effect at the first rising edge after it is presented. The bench drives inputs just after a falling edge and compares outputs one nanosecond later, before the next rising edge. Its reference model updates its copy of the configuration only after that rising edge. A write and a hit pattern driven in the same cycle are therefore judged against the old configuration, and the following cycle shows the new one.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int TRIG_PAIRS = 5;
  localparam int TRIG_NUM   = 2 * TRIG_PAIRS;
  localparam int IDX_W      = $clog2(TRIG_NUM);
  localparam int CFG_W      = 3;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_TIM_BIT   = 1;
  localparam int CFG_CHAIN_BIT = 2;

  typedef enum logic [1:0] {ROLE_FETCH = 2'd0, ROLE_STORE = 2'd1, ROLE_LOAD = 2'd2} trigRole_e;

  typedef struct packed {
    logic             entryWr;
    logic             chainWr;
    logic [IDX_W-1:0] idx;
    logic             enVal;
    logic             timVal;
    logic             chainVal;
  } cfgStrobe_t;

  function automatic trigRole_e roleOf(input int k);
    int grp;
    grp = (k / 2) % 5;
    case (grp)
      0: roleOf = ROLE_FETCH;
      1: roleOf = ROLE_STORE;
      2: roleOf = ROLE_LOAD;
      3: roleOf = (k % 2 == 0) ? ROLE_FETCH : ROLE_STORE;
      default: roleOf = (k % 2 == 0) ? ROLE_FETCH : ROLE_LOAD;
    endcase
  endfunction

  function automatic bit chainForbidden(input int p);
    chainForbidden = (roleOf(2*p) == ROLE_STORE) && (roleOf(2*p+1) == ROLE_STORE);
  endfunction
endpackage

// File: rtl/trig_cfg_ctrl.sv
module trig_cfg_ctrl
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS = TRIG_PAIRS
) (
  input  logic             cfgWrValid,
  input  logic [IDX_W-1:0] cfgWrIdx,
  input  logic [CFG_W-1:0] cfgWrData,
  output cfgStrobe_t       strobe
);
  localparam int NumTrig = 2 * NUM_PAIRS;

  logic inRange;
  assign inRange = ({1'b0, cfgWrIdx} < (IDX_W+1)'(NumTrig));

  always_comb begin
    strobe.entryWr  = cfgWrValid && inRange;
    strobe.chainWr  = cfgWrValid && inRange && !cfgWrIdx[0];
    strobe.idx      = cfgWrIdx;
    strobe.enVal    = cfgWrData[CFG_EN_BIT];
    strobe.timVal   = cfgWrData[CFG_TIM_BIT];
    strobe.chainVal = cfgWrData[CFG_CHAIN_BIT];
  end
endmodule

// File: rtl/trig_fire_dp.sv
module trig_fire_dp
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS = TRIG_PAIRS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfgStrobe_t             strobe,
  input  logic [2*NUM_PAIRS-1:0] hitVec,
  output logic [2*NUM_PAIRS-1:0] fireVec,
  output logic [2*NUM_PAIRS-1:0] enVec,
  output logic [2*NUM_PAIRS-1:0] timVec,
  output logic [NUM_PAIRS-1:0]   chainVec,
  output logic                   fireNow,
  output logic                   fireNext,
  output logic                   fetchHit,
  output logic                   memHit
);
  localparam int NumTrig = 2 * NUM_PAIRS;

  logic [NumTrig-1:0] fetchMask;

  for (genvar k = 0; k < NumTrig; k++) begin : g_trig
    assign fetchMask[k] = (roleOf(k) == ROLE_FETCH);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enVec[k]  <= 1'b0;
        timVec[k] <= 1'b0;
      end else if (strobe.entryWr && (strobe.idx == IDX_W'(k))) begin
        enVec[k]  <= strobe.enVal;
        timVec[k] <= strobe.timVal;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic qualA, qualB, both;
    if (chainForbidden(p)) begin : g_nochain
      assign chainVec[p] = 1'b0;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          chainVec[p] <= 1'b0;
        else if (strobe.chainWr && (strobe.idx == IDX_W'(2*p)))
          chainVec[p] <= strobe.chainVal;
      end
    end
    assign qualA = hitVec[2*p]   & enVec[2*p];
    assign qualB = hitVec[2*p+1] & enVec[2*p+1];
    assign both  = qualA & qualB & (timVec[2*p] == timVec[2*p+1]);
    assign fireVec[2*p]   = chainVec[p] ? both : qualA;
    assign fireVec[2*p+1] = chainVec[p] ? both : qualB;
  end

  assign fireNow  = |(fireVec & ~timVec);
  assign fireNext = |(fireVec & timVec);
  assign fetchHit = |(fireVec & fetchMask);
  assign memHit   = |(fireVec & ~fetchMask);
endmodule

// File: rtl/trig_resolver.sv
module trig_resolver
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS = TRIG_PAIRS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrValid,
  input  logic [IDX_W-1:0]       cfgWrIdx,
  input  logic [CFG_W-1:0]       cfgWrData,
  input  logic [2*NUM_PAIRS-1:0] hitVec,
  output logic [2*NUM_PAIRS-1:0] fireVec,
  output logic                   fireNow,
  output logic                   fireNext,
  output logic                   fetchHit,
  output logic                   memHit,
  output logic                   anyHit
);
  cfgStrobe_t                 strobe;
  logic [2*NUM_PAIRS-1:0]     enVec;
  logic [2*NUM_PAIRS-1:0]     timVec;
  logic [NUM_PAIRS-1:0]       chainVec;

  trig_cfg_ctrl #(.NUM_PAIRS(NUM_PAIRS)) u_ctrl (
    .cfgWrValid(cfgWrValid), .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData), .strobe(strobe)
  );

  trig_fire_dp #(.NUM_PAIRS(NUM_PAIRS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hitVec(hitVec), .fireVec(fireVec),
    .enVec(enVec), .timVec(timVec), .chainVec(chainVec), .fireNow(fireNow),
    .fireNext(fireNext), .fetchHit(fetchHit), .memHit(memHit)
  );

  assign anyHit = fetchHit | memHit;
endmodule

// File: rtl/trig_resolver_chk.sv
module trig_resolver_chk
  import trig_pkg::*;
#(
  parameter int NUM_PAIRS = TRIG_PAIRS
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgWrValid,
  input logic [IDX_W-1:0]       cfgWrIdx,
  input logic [CFG_W-1:0]       cfgWrData,
  input logic [2*NUM_PAIRS-1:0] hitVec,
  input logic [2*NUM_PAIRS-1:0] fireVec,
  input logic [2*NUM_PAIRS-1:0] enVec,
  input logic [2*NUM_PAIRS-1:0] timVec,
  input logic [NUM_PAIRS-1:0]   chainVec,
  input logic                   fireNow,
  input logic                   fireNext,
  input logic                   anyHit
);
  localparam int NumTrig = 2 * NUM_PAIRS;

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrValid && ({1'b0, cfgWrIdx} < (IDX_W+1)'(NumTrig))) |=>
      (enVec[$past(cfgWrIdx)] == $past(cfgWrData[CFG_EN_BIT])) &&
      (timVec[$past(cfgWrIdx)] == $past(cfgWrData[CFG_TIM_BIT])));

  a_r2_bad_index_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrValid && ({1'b0, cfgWrIdx} >= (IDX_W+1)'(NumTrig))) |=>
      $stable(enVec) && $stable(timVec) && $stable(chainVec));

  a_r3_fire_needs_hit_and_enable: assert property (@(posedge clk) disable iff (!rstN)
    ((fireVec & ~(hitVec & enVec)) == '0));

  a_r6_odd_write_keeps_chain: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrValid && cfgWrIdx[0]) |=> $stable(chainVec));

  a_r8_now_next_cover_fire: assert property (@(posedge clk) disable iff (!rstN)
    ((fireNow || fireNext) == (|fireVec)));

  a_r9_any_tracks_fire: assert property (@(posedge clk) disable iff (!rstN)
    (anyHit == (|fireVec)));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pchk
    a_r4_chain_fires_as_unit: assert property (@(posedge clk) disable iff (!rstN)
      chainVec[p] |-> (fireVec[2*p] == fireVec[2*p+1]));
    a_r5_timing_mismatch_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (chainVec[p] && (timVec[2*p] != timVec[2*p+1])) |-> !fireVec[2*p]);
    if (chainForbidden(p)) begin : g_ss
      a_r7_store_pair_unchained: assert property (@(posedge clk) disable iff (!rstN)
        !chainVec[p]);
    end
  end
endmodule

bind trig_resolver trig_resolver_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrValid(cfgWrValid), .cfgWrIdx(cfgWrIdx),
  .cfgWrData(cfgWrData), .hitVec(hitVec), .fireVec(fireVec), .enVec(enVec),
  .timVec(timVec), .chainVec(chainVec), .fireNow(fireNow), .fireNext(fireNext),
  .anyHit(anyHit)
);

// File: tb/sim_trig_resolver.sv
`timescale 1ns/1ps
module sim_trig_resolver;
  localparam int NT = 10;
  localparam int NP = 5;
  localparam logic [NT-1:0] FETCH_MASK = 10'h143;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrValid = 1'b0;
  logic [3:0] cfgWrIdx = '0;
  logic [2:0] cfgWrData = '0;
  logic [NT-1:0] hitVec = '0;
  logic [NT-1:0] fireVec;
  logic fireNow, fireNext, fetchHit, memHit, anyHit;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [NT-1:0] mEn = '0;
  logic [NT-1:0] mTim = '0;
  logic [NP-1:0] mChain = '0;

  always #2.5 clk = ~clk;

  trig_resolver u0 (
    .clk(clk), .rstN(rstN), .cfgWrValid(cfgWrValid), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .hitVec(hitVec), .fireVec(fireVec), .fireNow(fireNow),
    .fireNext(fireNext), .fetchHit(fetchHit), .memHit(memHit), .anyHit(anyHit)
  );

  function automatic logic [NT-1:0] expFire(input logic [NT-1:0] h);
    logic [NT-1:0] f;
    for (int p = 0; p < NP; p++) begin
      logic a, b;
      a = h[2*p] & mEn[2*p];
      b = h[2*p+1] & mEn[2*p+1];
      if (mChain[p]) begin
        f[2*p]   = a & b & (mTim[2*p] == mTim[2*p+1]);
        f[2*p+1] = f[2*p];
      end else begin
        f[2*p]   = a;
        f[2*p+1] = b;
      end
    end
    return f;
  endfunction

  function automatic logic [NT+4:0] expAll(input logic [NT-1:0] h);
    logic [NT-1:0] f;
    logic fe, me;
    f  = expFire(h);
    fe = |(f & FETCH_MASK);
    me = |(f & ~FETCH_MASK);
    return {f, |(f & ~mTim), |(f & mTim), fe, me, fe | me};
  endfunction

  task automatic step(input bit wv, input logic [3:0] wi, input logic [2:0] wd,
                      input logic [NT-1:0] h, input string tag);
    logic [NT+4:0] act, exp;
    @(negedge clk);
    cfgWrValid = wv; cfgWrIdx = wi; cfgWrData = wd; hitVec = h;
    #1;
    exp = expAll(h);
    act = {fireVec, fireNow, fireNext, fetchHit, memHit, anyHit};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: hit=%b got=%b exp=%b", tag, h, act, exp);
    end
    @(posedge clk);
    #0.1;
    if (wv && wi < NT) begin
      mEn[wi]  = wd[0];
      mTim[wi] = wd[1];
      if (wi[0] == 1'b0 && (wi >> 1) != 1) mChain[wi >> 1] = wd[2];
    end
    cfgWrValid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] wi, input logic [2:0] wd, input string tag);
    step(1'b1, wi, wd, '0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state, all hits high
    step(0, 0, 0, '1, "R1 reset all disabled");
    step(0, 0, 0, 10'h2AA, "R1 reset partial hits");
    // R2: bad index ignored
    wr(4'd10, 3'b111, "R2 out-of-range write");
    step(0, 0, 0, '1, "R2 out-of-range ignored");
    wr(4'd15, 3'b111, "R2 out-of-range write 15");
    // R2/R3: enable 0 and 9 (fetch and load roles)
    wr(4'd0, 3'b001, "R2 write t0");
    wr(4'd9, 3'b011, "R2 write t9");
    step(0, 0, 0, '1, "R3 R8 R9 unchained fetch now, load next");
    step(0, 0, 0, 10'h001, "R3 R9 fetch only");
    step(0, 0, 0, 10'h200, "R3 R9 mem only");
    // R4: chain pair 0
    wr(4'd1, 3'b001, "R2 write t1");
    wr(4'd0, 3'b101, "R6 chain pair0");
    step(0, 0, 0, 10'h001, "R4 chained one hit");
    step(0, 0, 0, 10'h003, "R4 chained both hit");
    // R5 timing mismatch
    wr(4'd1, 3'b011, "R2 t1 timing 1");
    step(0, 0, 0, 10'h003, "R5 chained timing mismatch");
    // R6 odd write with chain bit clears nothing
    wr(4'd1, 3'b101, "R6 odd write chain bit 1");
    step(0, 0, 0, 10'h003, "R6 chain still set, both fire");
    wr(4'd1, 3'b000, "R6 odd write chain 0, disable t1");
    step(0, 0, 0, 10'h003, "R4 R6 disabled partner blocks chain");
    // R7 store-store pair chain forced off
    wr(4'd2, 3'b101, "R7 write chain to store pair");
    wr(4'd3, 3'b001, "R2 enable t3");
    step(0, 0, 0, 10'h004, "R7 store pair stays unchained");
    // R8 next-timing fire through pair 3 (fetch+store)
    wr(4'd7, 3'b011, "R2 t7 timing 1");
    step(0, 0, 0, 10'h080, "R8 R9 store next");
    // write and hit same cycle: old config applies
    step(1, 4'd5, 3'b001, 10'h020, "R2 write same cycle not yet active");
    step(0, 0, 0, 10'h020, "R2 write active next cycle");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] wi;
      wi = 4'($urandom_range(0, 11));
      step(($urandom_range(0, 3) == 0), wi, 3'($urandom), 10'($urandom),
           "R3 R4 R5 R6 R7 R8 R9 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule